// File: doc/BRIEF.md
# Borrowing Shared-Buffer Queue Manager

This block keeps one logical queue per input port inside a single shared cell store. Each queue holds up to `DEPTH` cell identifiers. A port's own cells fill its queue from the low slot upward. When a port's queue is full, the manager finds the least occupied other queue that can still lend space and links the port to it. The port's further cells are then stored in that lender queue, which fills from its top slot downward. The lender's own arrivals grow toward the borrowed cells and overwrite the most recent of them once the queue is full.

Each cycle the manager takes at most one arrival (port and cell identifier) or one dequeue request (port). For an arrival it reports one cycle later whether the cell was stored in its own queue, stored in a lender, dropped, or stored by overwriting a borrowed cell, and in the last case which cell was lost. A dequeue returns the oldest cell of the port one cycle later. The occupancy of every queue and the active lending links are visible at all times, so a scheduler can see how the shared space is divided.

Top module: `sqb_manager`

## Requirements
- R1: After reset every owner count and lent count is 0, no link is valid, and `res_valid` and `deq_done` are 0.
- R2: An arrival for a port that has no active link and whose queue is not full is stored in its own queue. One cycle later `res_valid`=1, `res_code`=0 (own) and `res_queue` is the port.
- R3: Owner count plus lent count of a queue never exceeds `DEPTH`. A dropped arrival reports `res_code`=2 with `res_queue` equal to the arriving port and changes no count.
- R4: An arrival for a full queue with no lent cells and no active link is stored in the least occupied other queue that is not full and not already lending. Ties go to the lowest index. The report is `res_code`=1 (lent) with `res_queue` set to the lender, and `link_valid[p]`=1 with `link_lender` bits [p*PW +: PW] holding the lender. If no queue qualifies, the arrival is dropped.
- R5: While a port has an active link, its arrivals go to the lender (`res_code`=1) if the lender has space and are dropped otherwise, even if its own queue has space.
- R6: An arrival for a full queue that holds lent cells and has no active link of its own overwrites the most recently lent cell. It reports `res_code`=3 with `res_evict_id` set to the lost cell. The borrower's link ends when its last lent cell is overwritten.
- R7: A queue lends to at most one port at a time, and a port has at most one lender.
- R8: A dequeue returns the port's oldest cell one cycle later (`deq_done`=1, `deq_hit`=1, `deq_id`). The port's own cells come out in arrival order first, then its cells held by the lender in arrival order.
- R9: A dequeue for a port that holds no cell gives `deq_done`=1 and `deq_hit`=0 and changes no count.
- R10: A dequeue request in the same cycle as an arrival is ignored (`deq_done`=0 the next cycle).
- R11: A port's link ends when its last cell held by the lender is dequeued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Arrival present this cycle |
| arr_port | input | PW | Port of the arriving cell |
| arr_id | input | IDW | Identifier of the arriving cell |
| deq_valid | input | 1 | Dequeue request this cycle |
| deq_port | input | PW | Port to dequeue from |
| res_valid | output | 1 | Arrival result valid |
| res_code | output | 2 | 0 own, 1 lent, 2 drop, 3 overwrite |
| res_queue | output | PW | Queue written (arriving port on drop) |
| res_evict_id | output | IDW | Identifier lost on overwrite |
| deq_done | output | 1 | Dequeue request handled |
| deq_hit | output | 1 | A cell was returned |
| deq_id | output | IDW | Identifier of the returned cell |
| own_cnt | output | NPORTS*CW | Owner count of queue q at [q*CW +: CW] |
| lent_cnt | output | NPORTS*CW | Lent cells held in queue q at [q*CW +: CW] |
| link_valid | output | NPORTS | Port p has an active lender |
| link_lender | output | NPORTS*PW | Lender of port p at [p*PW +: PW] |

## Verification
Arrival results and dequeue results are registered, so each appears exactly one clock edge after the request. The counts and link outputs also change on that same edge. The bench changes inputs on the falling edge, lets one rising edge pass, and compares every output at the following falling edge before it applies the next stimulus. Link and count outputs are read at points between stimulus rows, so every lending decision and every release is checked at the ports.

// File: rtl/sqb_pkg.sv
package sqb_pkg;

   typedef enum logic [2:0] {
      Q_IDLE,
      Q_PUSH_OWN,
      Q_POP_OWN,
      Q_PUSH_LENT,
      Q_POP_LENT,
      Q_EVICT
   } q_op_e;

   typedef enum logic [1:0] {
      RES_OWN   = 2'd0,
      RES_LENT  = 2'd1,
      RES_DROP  = 2'd2,
      RES_EVICT = 2'd3
   } res_e;

endpackage

// File: rtl/sqb_queue.sv
module sqb_queue
   import sqb_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int IDW   = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  q_op_e          op,
   input  logic [IDW-1:0] wr_id,
   output logic [CW-1:0]  own_cnt,
   output logic [CW-1:0]  lent_cnt,
   output logic [IDW-1:0] head_id,
   output logic [IDW-1:0] lent_old_id,
   output logic [IDW-1:0] lent_new_id
);

   localparam logic [CW-1:0] ONE = CW'(1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sqb_queue: DEPTH must be at least 2");
   end

   logic [IDW-1:0] slot [DEPTH];
   logic [CW-1:0]  own_q, lent_q;

   assign own_cnt     = own_q;
   assign lent_cnt    = lent_q;
   assign head_id     = slot[0];
   assign lent_old_id = slot[DEPTH-1];

   always_comb begin
      lent_new_id = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (lent_q != '0 && k == DEPTH - int'(lent_q)) lent_new_id = slot[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q  <= '0;
         lent_q <= '0;
         for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
      end else begin
         unique case (op)
            Q_PUSH_OWN: begin
               own_q <= own_q + ONE;
               for (int k = 0; k < DEPTH; k++)
                  if (k == int'(own_q)) slot[k] <= wr_id;
            end
            Q_POP_OWN: begin
               own_q <= own_q - ONE;
               for (int k = 0; k < DEPTH - 1; k++)
                  if (k + 1 < int'(own_q)) slot[k] <= slot[k+1];
            end
            Q_PUSH_LENT: begin
               lent_q <= lent_q + ONE;
               for (int k = 0; k < DEPTH; k++)
                  if (k == DEPTH - 1 - int'(lent_q)) slot[k] <= wr_id;
            end
            Q_POP_LENT: begin
               lent_q <= lent_q - ONE;
               for (int k = 1; k < DEPTH; k++)
                  if (k > DEPTH - int'(lent_q)) slot[k] <= slot[k-1];
            end
            Q_EVICT: begin
               own_q  <= own_q + ONE;
               lent_q <= lent_q - ONE;
               for (int k = 0; k < DEPTH; k++)
                  if (k == int'(own_q)) slot[k] <= wr_id;
            end
            default: ;
         endcase
      end
   end

   // R3: owner and lent cells together never exceed the queue depth
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(own_q) + int'(lent_q)) <= DEPTH);

   // R8: an owner pop is only issued when the owner region holds a cell
   p_pop_own_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op == Q_POP_OWN |-> own_q != '0);

   // R11: a lent pop is only issued when lent cells are present
   p_pop_lent_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      op == Q_POP_LENT |-> lent_q != '0);

   // R6: an overwrite needs a full queue with a lent cell in it
   p_evict_needs_lent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op == Q_EVICT |-> (lent_q != '0) && (int'(own_q) + int'(lent_q) == DEPTH));

endmodule

// File: rtl/sqb_pick.sv
module sqb_pick #(
   parameter int NPORTS = 4,
   parameter int CW     = 3,
   parameter int PW     = $clog2(NPORTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPORTS*CW-1:0] occ_flat,
   input  logic [NPORTS-1:0]    eligible,
   output logic                 found,
   output logic [PW-1:0]        pick
);

   logic [CW-1:0] best;

   always_comb begin
      found = 1'b0;
      pick  = '0;
      best  = '1;
      for (int i = 0; i < NPORTS; i++) begin
         if (eligible[i] && (!found || occ_flat[i*CW +: CW] < best)) begin
            found = 1'b1;
            pick  = PW'(i);
            best  = occ_flat[i*CW +: CW];
         end
      end
   end

   // R4: a chosen lender is always one of the eligible queues
   p_pick_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> eligible[pick]);

   // R4: nothing is chosen only when no queue qualifies
   p_none_means_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> eligible == '0);

endmodule

// File: rtl/sqb_manager.sv
module sqb_manager
   import sqb_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int DEPTH  = 6,
   parameter int IDW    = 8,
   localparam int PW    = $clog2(NPORTS),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arr_valid,
   input  logic [PW-1:0]        arr_port,
   input  logic [IDW-1:0]       arr_id,
   input  logic                 deq_valid,
   input  logic [PW-1:0]        deq_port,
   output logic                 res_valid,
   output logic [1:0]           res_code,
   output logic [PW-1:0]        res_queue,
   output logic [IDW-1:0]       res_evict_id,
   output logic                 deq_done,
   output logic                 deq_hit,
   output logic [IDW-1:0]       deq_id,
   output logic [NPORTS*CW-1:0] own_cnt,
   output logic [NPORTS*CW-1:0] lent_cnt,
   output logic [NPORTS-1:0]    link_valid,
   output logic [NPORTS*PW-1:0] link_lender
);

   localparam int SW = $clog2(NPORTS * DEPTH + 1);

   if (NPORTS < 3) begin : g_bad_ports
      $error("sqb_manager: NPORTS must be at least 3");
   end
   if (IDW < 1) begin : g_bad_idw
      $error("sqb_manager: IDW must be at least 1");
   end

   // queue storage
   q_op_e          q_op     [NPORTS];
   logic [CW-1:0]  own_c    [NPORTS];
   logic [CW-1:0]  lent_c   [NPORTS];
   logic [CW-1:0]  occ      [NPORTS];
   logic [IDW-1:0] head     [NPORTS];
   logic [IDW-1:0] lent_old [NPORTS];
   logic [IDW-1:0] lent_new [NPORTS];
   logic [NPORTS*CW-1:0] occ_flat;

   for (genvar q = 0; q < NPORTS; q++) begin : g_queue
      sqb_queue #(.DEPTH(DEPTH), .IDW(IDW), .CW(CW)) i_queue (
         .clk         (clk),
         .rst_n       (rst_n),
         .op          (q_op[q]),
         .wr_id       (arr_id),
         .own_cnt     (own_c[q]),
         .lent_cnt    (lent_c[q]),
         .head_id     (head[q]),
         .lent_old_id (lent_old[q]),
         .lent_new_id (lent_new[q])
      );
      assign occ[q]                = own_c[q] + lent_c[q];
      assign occ_flat[q*CW +: CW]  = occ[q];
      assign own_cnt[q*CW +: CW]   = own_c[q];
      assign lent_cnt[q*CW +: CW]  = lent_c[q];
   end

   // lending links
   logic          link_v_q [NPORTS];
   logic [PW-1:0] link_l_q [NPORTS];
   logic          link_v_d [NPORTS];
   logic [PW-1:0] link_l_d [NPORTS];
   logic [NPORTS-1:0] busy, eligible;
   logic          pick_found;
   logic [PW-1:0] pick_idx;

   always_comb begin
      busy = '0;
      for (int p = 0; p < NPORTS; p++)
         for (int j = 0; j < NPORTS; j++)
            if (link_v_q[p] && int'(link_l_q[p]) == j) busy[j] = 1'b1;
   end

   always_comb begin
      for (int j = 0; j < NPORTS; j++)
         eligible[j] = (j != int'(arr_port)) && (occ[j] < CW'(DEPTH)) && !busy[j];
   end

   sqb_pick #(.NPORTS(NPORTS), .CW(CW), .PW(PW)) i_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .occ_flat (occ_flat),
      .eligible (eligible),
      .found    (pick_found),
      .pick     (pick_idx)
   );

   // arrival / dequeue decision
   res_e           code_d;
   logic [PW-1:0]  resq_d;
   logic [IDW-1:0] evict_d;
   logic           deq_take, hit_d;
   logic [IDW-1:0] did_d;

   always_comb begin
      int ap, dp, ln;
      ap       = int'(arr_port);
      dp       = int'(deq_port);
      ln       = 0;
      code_d   = RES_DROP;
      resq_d   = arr_port;
      evict_d  = '0;
      deq_take = deq_valid && !arr_valid;
      hit_d    = 1'b0;
      did_d    = '0;
      for (int q = 0; q < NPORTS; q++) begin
         q_op[q]     = Q_IDLE;
         link_v_d[q] = link_v_q[q];
         link_l_d[q] = link_l_q[q];
      end
      if (arr_valid) begin
         if (link_v_q[ap]) begin
            ln = int'(link_l_q[ap]);
            if (occ[ln] < CW'(DEPTH)) begin
               q_op[ln] = Q_PUSH_LENT;
               code_d   = RES_LENT;
               resq_d   = link_l_q[ap];
            end
         end else if (occ[ap] < CW'(DEPTH)) begin
            q_op[ap] = Q_PUSH_OWN;
            code_d   = RES_OWN;
         end else if (lent_c[ap] != '0) begin
            q_op[ap] = Q_EVICT;
            code_d   = RES_EVICT;
            evict_d  = lent_new[ap];
            if (lent_c[ap] == CW'(1))
               for (int q = 0; q < NPORTS; q++)
                  if (link_v_q[q] && link_l_q[q] == arr_port) link_v_d[q] = 1'b0;
         end else if (pick_found) begin
            q_op[int'(pick_idx)] = Q_PUSH_LENT;
            code_d       = RES_LENT;
            resq_d       = pick_idx;
            link_v_d[ap] = 1'b1;
            link_l_d[ap] = pick_idx;
         end
      end else if (deq_valid) begin
         if (own_c[dp] != '0) begin
            q_op[dp] = Q_POP_OWN;
            hit_d    = 1'b1;
            did_d    = head[dp];
         end else if (link_v_q[dp]) begin
            ln       = int'(link_l_q[dp]);
            q_op[ln] = Q_POP_LENT;
            hit_d    = 1'b1;
            did_d    = lent_old[ln];
            if (lent_c[ln] == CW'(1)) link_v_d[dp] = 1'b0;
         end
      end
   end

   // registered state and results
   res_e res_code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < NPORTS; q++) begin
            link_v_q[q] <= 1'b0;
            link_l_q[q] <= '0;
         end
         res_valid    <= 1'b0;
         res_code_q   <= RES_OWN;
         res_queue    <= '0;
         res_evict_id <= '0;
         deq_done     <= 1'b0;
         deq_hit      <= 1'b0;
         deq_id       <= '0;
      end else begin
         for (int q = 0; q < NPORTS; q++) begin
            link_v_q[q] <= link_v_d[q];
            link_l_q[q] <= link_l_d[q];
         end
         res_valid    <= arr_valid;
         res_code_q   <= code_d;
         res_queue    <= resq_d;
         res_evict_id <= evict_d;
         deq_done     <= deq_take;
         deq_hit      <= hit_d;
         deq_id       <= did_d;
      end
   end

   assign res_code = res_code_q;

   for (genvar p = 0; p < NPORTS; p++) begin : g_link_out
      assign link_valid[p]           = link_v_q[p];
      assign link_lender[p*PW +: PW] = link_l_q[p];
   end

   // totals used by the checks below
   logic [SW-1:0] own_sum, lent_sum;
   always_comb begin
      own_sum  = '0;
      lent_sum = '0;
      for (int q = 0; q < NPORTS; q++) begin
         own_sum  = own_sum + SW'(own_c[q]);
         lent_sum = lent_sum + SW'(lent_c[q]);
      end
   end

   // R7: each queue has at most one borrower
   for (genvar j = 0; j < NPORTS; j++) begin : g_one_borrower
      logic [NPORTS-1:0] brw;
      always_comb
         for (int p = 0; p < NPORTS; p++)
            brw[p] = link_v_q[p] && int'(link_l_q[p]) == j;
      p_one_borrower_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(brw));
   end

   // R5: an active link always points at another queue holding lent cells
   for (genvar p = 0; p < NPORTS; p++) begin : g_link_chk
      p_link_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
         link_v_q[p] |-> (int'(link_l_q[p]) != p) && (lent_c[link_l_q[p]] != '0));
   end

   // R2: an own result adds exactly one owner cell
   p_own_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_code_q == RES_OWN |->
         own_sum == $past(own_sum) + SW'(1) && $stable(lent_sum));

   // R3: a drop leaves every count unchanged
   p_drop_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_code_q == RES_DROP |-> $stable(own_sum) && $stable(lent_sum));

   // R6: an overwrite turns one lent cell into an owner cell
   p_evict_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_code_q == RES_EVICT |->
         own_sum == $past(own_sum) + SW'(1) && lent_sum == $past(lent_sum) - SW'(1));

   // R9: a dequeue miss changes no count
   p_miss_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      deq_done && !deq_hit |-> $stable(own_sum) && $stable(lent_sum));

endmodule

// File: tb/test_sqb_manager.sv
module test_sqb_manager;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int CW = 3;
   localparam int PW = 2;

   logic          clk, rst_n;
   logic          arr_valid, deq_valid;
   logic [PW-1:0] arr_port, deq_port;
   logic [7:0]    arr_id;
   logic          res_valid, deq_done, deq_hit;
   logic [1:0]    res_code;
   logic [PW-1:0] res_queue;
   logic [7:0]    res_evict_id, deq_id;
   logic [NP*CW-1:0] own_cnt, lent_cnt;
   logic [NP-1:0]    link_valid;
   logic [NP*PW-1:0] link_lender;

   int n_chk  = 0;
   int n_fail = 0;

   sqb_manager #(.NPORTS(NP), .DEPTH(6), .IDW(8)) i_sqb_manager (
      .clk(clk), .rst_n(rst_n),
      .arr_valid(arr_valid), .arr_port(arr_port), .arr_id(arr_id),
      .deq_valid(deq_valid), .deq_port(deq_port),
      .res_valid(res_valid), .res_code(res_code), .res_queue(res_queue),
      .res_evict_id(res_evict_id),
      .deq_done(deq_done), .deq_hit(deq_hit), .deq_id(deq_id),
      .own_cnt(own_cnt), .lent_cnt(lent_cnt),
      .link_valid(link_valid), .link_lender(link_lender)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // code: 0 own, 1 lent, 2 drop, 3 overwrite
   typedef struct packed {
      logic          av;
      logic [1:0]    ap;
      logic [7:0]    aid;
      logic          dv;
      logic [1:0]    dp;
      logic [1:0]    ecode;
      logic [1:0]    eq;
      logic [7:0]    eev;
      logic          ehit;
      logic [7:0]    eid;
      logic [3:0]    req;
   } vec_t;

   localparam int NROWS = 23;
   localparam vec_t TBL [NROWS] = '{
      '{1'b1, 2'd0, 8'h06, 1'b0, 2'd0, 2'd1, 2'd1, 8'h00, 1'b0, 8'h00, 4'd4},  // R4 borrow from q1
      '{1'b1, 2'd1, 8'h12, 1'b0, 2'd0, 2'd0, 2'd1, 8'h00, 1'b0, 8'h00, 4'd2},
      '{1'b1, 2'd1, 8'h13, 1'b0, 2'd0, 2'd0, 2'd1, 8'h00, 1'b0, 8'h00, 4'd2},
      '{1'b1, 2'd1, 8'h14, 1'b0, 2'd0, 2'd0, 2'd1, 8'h00, 1'b0, 8'h00, 4'd2},
      '{1'b1, 2'd1, 8'h15, 1'b0, 2'd0, 2'd3, 2'd1, 8'h06, 1'b0, 8'h00, 4'd6},  // R6 overwrite
      '{1'b1, 2'd0, 8'h08, 1'b0, 2'd0, 2'd1, 2'd3, 8'h00, 1'b0, 8'h00, 4'd4},  // R4 new lender q3
      '{1'b1, 2'd1, 8'h16, 1'b0, 2'd0, 2'd1, 2'd2, 8'h00, 1'b0, 8'h00, 4'd4},  // R4 q3 busy -> q2
      '{1'b1, 2'd3, 8'h33, 1'b1, 2'd0, 2'd0, 2'd3, 8'h00, 1'b0, 8'h00, 4'd10}, // R10 deq ignored
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd0, 2'd0, 2'd0, 8'h00, 1'b1, 8'h00, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 2'd0, 2'd0, 8'h00, 1'b1, 8'h20, 4'd8},
      '{1'b1, 2'd3, 8'h34, 1'b0, 2'd0, 2'd0, 2'd3, 8'h00, 1'b0, 8'h00, 4'd2},
      '{1'b1, 2'd0, 8'h09, 1'b0, 2'd0, 2'd2, 2'd0, 8'h00, 1'b0, 8'h00, 4'd5},  // R5 lender full
      '{1'b1, 2'd3, 8'h35, 1'b0, 2'd0, 2'd3, 2'd3, 8'h08, 1'b0, 8'h00, 4'd6},  // R6 overwrite
      '{1'b1, 2'd2, 8'h24, 1'b0, 2'd0, 2'd0, 2'd2, 8'h00, 1'b0, 8'h00, 4'd2},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h10, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h11, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h12, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h13, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h14, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h15, 4'd8},
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b1, 8'h16, 4'd11}, // R11 last lent cell
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 2'd0, 2'd0, 8'h00, 1'b0, 8'h00, 4'd9},  // R9 miss
      '{1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 2'd0, 2'd0, 8'h00, 1'b1, 8'h21, 4'd8}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic av, input logic [1:0] ap, input logic [7:0] aid,
                        input logic dv, input logic [1:0] dp);
      arr_valid = av; arr_port = ap; arr_id = aid;
      deq_valid = dv; deq_port = dp;
      @(negedge clk);
      arr_valid = 1'b0;
      deq_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      arr_valid = 1'b0; arr_port = '0; arr_id = '0;
      deq_valid = 1'b0; deq_port = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic fill(input int p, input int n, input int base);
      for (int k = 0; k < n; k++) begin
         drive(1'b1, 2'(p), 8'(base + k), 1'b0, 2'd0);
         chk("R2", "fill code", res_code, 0);
      end
   endtask

   task automatic run_rows(input int lo, input int hi);
      for (int r = lo; r <= hi; r++) begin
         vec_t v;
         string rq;
         v  = TBL[r];
         rq = $sformatf("R%0d", v.req);
         drive(v.av, v.ap, v.aid, v.dv, v.dp);
         chk(rq, $sformatf("row %0d res_valid", r), res_valid, v.av);
         if (v.av) begin
            chk(rq, $sformatf("row %0d res_code", r), res_code, v.ecode);
            chk(rq, $sformatf("row %0d res_queue", r), res_queue, v.eq);
            if (v.ecode == 2'd3)
               chk(rq, $sformatf("row %0d evict id", r), res_evict_id, v.eev);
         end
         chk(rq, $sformatf("row %0d deq_done", r), deq_done, v.dv && !v.av);
         if (v.dv && !v.av) begin
            chk(rq, $sformatf("row %0d deq_hit", r), deq_hit, v.ehit);
            if (v.ehit) chk(rq, $sformatf("row %0d deq_id", r), deq_id, v.eid);
         end
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", "own_cnt", int'(own_cnt), 0);
      chk("R1", "lent_cnt", int'(lent_cnt), 0);
      chk("R1", "link_valid", int'(link_valid), 0);
      chk("R1", "res_valid", res_valid, 0);
      chk("R1", "deq_done", deq_done, 0);

      // R4 tie: all peers empty -> lowest index lender q1
      fill(0, 6, 8'h40);
      drive(1'b1, 2'd0, 8'h50, 1'b0, 2'd0);
      chk("R4", "tie code", res_code, 1);
      chk("R4", "tie lender", res_queue, 1);
      chk("R4", "link_valid", link_valid[0], 1);
      chk("R4", "link_lender", link_lender[1:0], 1);
      chk("R4", "q1 lent", lent_cnt[1*CW +: CW], 1);
      // R5 link active: next cell goes to the lender
      drive(1'b1, 2'd0, 8'h51, 1'b0, 2'd0);
      chk("R5", "code", res_code, 1);
      chk("R5", "queue", res_queue, 1);
      // R8 order: own 40..45 then lent 50, 51
      for (int k = 0; k < 8; k++) begin
         int e;
         e = (k < 6) ? 8'h40 + k : 8'h50 + (k - 6);
         drive(1'b0, 2'd0, 8'h00, 1'b1, 2'd0);
         chk("R8", "order hit", deq_hit, 1);
         chk("R8", "order id", deq_id, e);
      end
      chk("R11", "link released", link_valid[0], 0);
      chk("R11", "q1 lent", lent_cnt[1*CW +: CW], 0);

      // R3 all full: no lender -> drop, counts kept
      do_reset();
      for (int p = 0; p < NP; p++) fill(p, 6, 8'h60 + 8 * p);
      drive(1'b1, 2'd2, 8'h99, 1'b0, 2'd0);
      chk("R3", "drop code", res_code, 2);
      chk("R3", "drop queue", res_queue, 2);
      chk("R3", "q2 own", own_cnt[2*CW +: CW], 6);
      chk("R3", "no link", int'(link_valid), 0);

      // shared-pool scenario with occupancies 6, 2, 4, 3
      do_reset();
      fill(0, 6, 8'h00);
      fill(1, 2, 8'h10);
      fill(2, 4, 8'h20);
      fill(3, 3, 8'h30);
      run_rows(0, 6);
      // R7 distinct lenders per port
      chk("R7", "links", int'(link_valid), 4'b0011);
      chk("R7", "lender p0", link_lender[1:0], 3);
      chk("R7", "lender p1", link_lender[3:2], 2);
      run_rows(7, NROWS - 1);
      chk("R11", "all links released", int'(link_valid), 0);
      chk("R9", "q1 empty", own_cnt[1*CW +: CW], 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule